// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block takes interrupts for an 8-bit processor core with a 16-bit address space. At each instruction boundary the core raises `step_i` and shows its current interrupt flip-flops, pending-enable flag, halt status, interrupt mode, program counter, stack pointer and interrupt page register. If a request is accepted, the sequencer pushes the return address onto the stack through a byte-wide write port. In the table mode it then fetches the handler address through a byte-wide read port. At the end it presents the new program counter, stack pointer and flip-flop values for a single cycle.

A non-maskable request is always taken and takes precedence over a maskable one. A maskable request is taken only while interrupts are enabled. It goes to one of three places: a restart address encoded in the vector byte, a fixed handler address, or an address read from a table in memory. An enable-interrupts instruction takes effect one instruction late. The sequencer holds off maskable acceptance until the instruction after it has completed, and it signals that release to the core.

Top module: `irq_accept_seq`

## Requirements
- R1: A maskable request (`int_req_i`) is accepted at a step only when `iff1_i` is 1 or the enable is being released (R10). When it is refused there is no memory write, `busy_o` stays low and `done_o` never pulses.
- R2: When `nmi_req_i` and `int_req_i` are both high at a step, the non-maskable request is served. The new PC is 0x0066 and the table is not read.
- R3: On acceptance the PC high byte is written at SP-1 and, in the next cycle, the PC low byte at SP-2, with 16-bit wrap. `sp_o` equals SP-2 when `done_o` is high.
- R4: A non-maskable acceptance gives `pc_o` = 0x0066, `iff1_o` = 0 and `ei_pend_o` = 0. `iff2_o` takes the value IFF1 had at the step.
- R5: A maskable acceptance gives `iff1_o`, `iff2_o` and `ei_pend_o` all 0.
- R6: When `im_i` is 2 or 3, a maskable acceptance reads the low byte at {`ireg_i`, `vec_i`} and the high byte at the next address. The new PC is high:low. The read data is expected on `mem_rdata_i` in the cycle after `mem_rd_o`.
- R7: When `im_i` = 1, a maskable acceptance gives `pc_o` = 0x0038, whatever the vector byte.
- R8: When `im_i` = 0 and the vector has the form 11nnn111 (binary), `pc_o` = 0x00 + nnn*8. Any other vector leaves `pc_o` equal to the pushed PC.
- R9: If `halt_i` is high on acceptance, the pushed PC is `pc_i`+1 and `halt_clr_o` pulses together with `done_o`. Otherwise `halt_clr_o` stays low.
- R10: At the first step with `ei_pend_i` high, maskable requests are refused. At the next step with `ei_pend_i` still high, IFF1 becomes 1 and the pending flag clears, and a maskable request at that same step is accepted. Without a request, `flags_upd_o` pulses in the cycle after that step with `iff1_o` = 1 and `ei_pend_o` = 0. A non-maskable request is accepted at either step.
- R11: `busy_o` is high from the cycle after the accepting step through the last push or read cycle. `done_o` is a one-cycle pulse (with `flags_upd_o`) 3 cycles after the step edge, or 6 cycles after it in table mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | Instruction boundary strobe |
| nmi_req_i | input | 1 | Non-maskable request |
| int_req_i | input | 1 | Maskable request |
| vec_i | input | 8 | Vector byte from the requester |
| iff1_i | input | 1 | Current interrupt enable flip-flop 1 |
| iff2_i | input | 1 | Current interrupt enable flip-flop 2 |
| ei_pend_i | input | 1 | Enable-interrupts instruction not yet in effect |
| halt_i | input | 1 | Core is halted |
| im_i | input | 2 | Interrupt mode: 0 restart, 1 fixed, 2 or 3 table |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| ireg_i | input | 8 | Interrupt page register |
| mem_we_o | output | 1 | Stack write strobe |
| mem_rd_o | output | 1 | Table read strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, one cycle after `mem_rd_o` |
| busy_o | output | 1 | Push or table read in progress |
| done_o | output | 1 | New PC, SP and flags valid |
| flags_upd_o | output | 1 | New flip-flop values valid |
| pc_o | output | 16 | New program counter |
| sp_o | output | 16 | New stack pointer |
| iff1_o | output | 1 | New IFF1 |
| iff2_o | output | 1 | New IFF2 |
| ei_pend_o | output | 1 | New pending-enable flag |
| halt_clr_o | output | 1 | Halt state is to be cleared |

## Verification
The assertions assume that the memory answers a read in exactly the next cycle. They also assume that the core holds `pc_i`, `sp_i`, `vec_i` and `ireg_i` steady while `busy_o` is high. The stimulus changes inputs only at falling edges and raises `step_i` for one cycle at a time, only while the sequencer is idle. The bench memory returns a byte computed from the read address, so a table fetch from any location has a known expected value. The enable-release tests keep `ei_pend_i` high across two consecutive steps, as a core would until it sees `flags_upd_o`.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_HI,
        S_PUSH_LO,
        S_RD_LO,
        S_RD_HI,
        S_RD_END,
        S_FIN,
        S_REL
    } seq_state_e;

    localparam logic [1:0] MODE_RESTART = 2'd0;
    localparam logic [1:0] MODE_FIXED   = 2'd1;

endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter (
    input  logic step,
    input  logic nmi_req,
    input  logic int_req,
    input  logic iff1,
    input  logic iff2,
    input  logic ei_pend,
    input  logic ei_wait_q,
    output logic take_nmi,
    output logic take_int,
    output logic release_en,
    output logic new_iff1,
    output logic new_iff2,
    output logic new_ei_pend,
    output logic new_ei_wait
);
    logic hold_first;
    logic eff_iff1;

    always_comb begin
        hold_first = step && ei_pend && !ei_wait_q;
        release_en = step && ei_pend && ei_wait_q;
        eff_iff1   = iff1 || release_en;
        take_nmi   = step && nmi_req;
        take_int   = step && !nmi_req && int_req && eff_iff1 && !hold_first;

        if (take_nmi || take_int) begin
            new_iff1 = 1'b0;
        end else if (release_en) begin
            new_iff1 = 1'b1;
        end else begin
            new_iff1 = iff1;
        end

        if (take_nmi) begin
            new_iff2 = eff_iff1;
        end else if (take_int) begin
            new_iff2 = 1'b0;
        end else begin
            new_iff2 = iff2;
        end

        new_ei_pend = (take_nmi || take_int || release_en) ? 1'b0 : ei_pend;

        if (take_nmi || release_en || !ei_pend) begin
            new_ei_wait = 1'b0;
        end else if (hold_first) begin
            new_ei_wait = 1'b1;
        end else begin
            new_ei_wait = ei_wait_q;
        end
    end

    // R2: never serve both kinds of request at one step
    always_comb begin
        p_single_take_r2: assert (!(take_nmi && take_int));
    end

endmodule

// File: rtl/irq_target.sv
module irq_target #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] NMI_ADDR   = 16'h0066,
    parameter logic [2*DW-1:0] FIXED_ADDR = 16'h0038
) (
    input  logic              take_nmi,
    input  logic [1:0]        im,
    input  logic [DW-1:0]     vec,
    input  logic [2*DW-1:0]   pc_push,
    output logic [2*DW-1:0]   target,
    output logic              use_table
);
    import irq_seq_pkg::*;

    localparam int AW = 2 * DW;
    localparam logic [DW-1:0] RST_FORM = DW'(8'hC7);
    localparam logic [DW-1:0] RST_SEL  = DW'(8'h38);

    logic is_restart;

    always_comb begin
        is_restart = (vec & RST_FORM) == RST_FORM;
        use_table  = !take_nmi && im[1];
        if (take_nmi) begin
            target = NMI_ADDR;
        end else if (im == MODE_FIXED) begin
            target = FIXED_ADDR;
        end else if (im == MODE_RESTART) begin
            target = is_restart ? AW'(vec & RST_SEL) : pc_push;
        end else begin
            target = '0;
        end
    end

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
    parameter int DW = 8,
    parameter logic [2*DW-1:0] NMI_ADDR   = 16'h0066,
    parameter logic [2*DW-1:0] FIXED_ADDR = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              nmi_req_i,
    input  logic              int_req_i,
    input  logic [DW-1:0]     vec_i,
    input  logic              iff1_i,
    input  logic              iff2_i,
    input  logic              ei_pend_i,
    input  logic              halt_i,
    input  logic [1:0]        im_i,
    input  logic [2*DW-1:0]   pc_i,
    input  logic [2*DW-1:0]   sp_i,
    input  logic [DW-1:0]     ireg_i,
    output logic              mem_we_o,
    output logic              mem_rd_o,
    output logic [2*DW-1:0]   mem_addr_o,
    output logic [DW-1:0]     mem_wdata_o,
    input  logic [DW-1:0]     mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              flags_upd_o,
    output logic [2*DW-1:0]   pc_o,
    output logic [2*DW-1:0]   sp_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic              ei_pend_o,
    output logic              halt_clr_o
);
    import irq_seq_pkg::*;

    localparam int AW = 2 * DW;

    typedef struct packed {
        seq_state_e      st;
        logic [AW-1:0]   pc;
        logic [AW-1:0]   sp;
        logic [AW-1:0]   tgt;
        logic [AW-1:0]   tbl_addr;
        logic            tbl;
        logic            iff1;
        logic            iff2;
        logic            eip;
        logic            halt;
        logic            ei_wait;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic          take_nmi, take_int, release_en;
    logic          nx_iff1, nx_iff2, nx_eip, nx_wait;
    logic [AW-1:0] pc_push;
    logic [AW-1:0] fixed_tgt;
    logic          use_table;

    assign pc_push = pc_i + AW'(halt_i);

    irq_arbiter u_arb (
        .step        (step_i && (r_q.st == S_IDLE)),
        .nmi_req     (nmi_req_i),
        .int_req     (int_req_i),
        .iff1        (iff1_i),
        .iff2        (iff2_i),
        .ei_pend     (ei_pend_i),
        .ei_wait_q   (r_q.ei_wait),
        .take_nmi    (take_nmi),
        .take_int    (take_int),
        .release_en  (release_en),
        .new_iff1    (nx_iff1),
        .new_iff2    (nx_iff2),
        .new_ei_pend (nx_eip),
        .new_ei_wait (nx_wait)
    );

    irq_target #(
        .DW         (DW),
        .NMI_ADDR   (NMI_ADDR),
        .FIXED_ADDR (FIXED_ADDR)
    ) u_tgt (
        .take_nmi  (take_nmi),
        .im        (im_i),
        .vec       (vec_i),
        .pc_push   (pc_push),
        .target    (fixed_tgt),
        .use_table (use_table)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            S_IDLE: begin
                if (step_i) begin
                    r_d.ei_wait = nx_wait;
                    r_d.iff1    = nx_iff1;
                    r_d.iff2    = nx_iff2;
                    r_d.eip     = nx_eip;
                    if (take_nmi || take_int) begin
                        r_d.pc       = pc_push;
                        r_d.sp       = sp_i;
                        r_d.tgt      = fixed_tgt;
                        r_d.tbl_addr = {ireg_i, vec_i};
                        r_d.tbl      = use_table;
                        r_d.halt     = halt_i;
                        r_d.st       = S_PUSH_HI;
                    end else if (release_en) begin
                        r_d.halt = 1'b0;
                        r_d.st   = S_REL;
                    end
                end
            end
            S_PUSH_HI: r_d.st = S_PUSH_LO;
            S_PUSH_LO: r_d.st = r_q.tbl ? S_RD_LO : S_FIN;
            S_RD_LO:   r_d.st = S_RD_HI;
            S_RD_HI: begin
                r_d.tgt[DW-1:0] = mem_rdata_i;
                r_d.st          = S_RD_END;
            end
            S_RD_END: begin
                r_d.tgt[AW-1:DW] = mem_rdata_i;
                r_d.st           = S_FIN;
            end
            S_FIN:   r_d.st = S_IDLE;
            S_REL:   r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_we_o    = 1'b0;
        mem_rd_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (r_q.st)
            S_PUSH_HI: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.sp - AW'(1);
                mem_wdata_o = r_q.pc[AW-1:DW];
            end
            S_PUSH_LO: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = r_q.sp - AW'(2);
                mem_wdata_o = r_q.pc[DW-1:0];
            end
            S_RD_LO: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = r_q.tbl_addr;
            end
            S_RD_HI: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = r_q.tbl_addr + AW'(1);
            end
            default: ;
        endcase
    end

    assign busy_o      = (r_q.st == S_PUSH_HI) || (r_q.st == S_PUSH_LO) ||
                         (r_q.st == S_RD_LO)   || (r_q.st == S_RD_HI)   ||
                         (r_q.st == S_RD_END);
    assign done_o      = (r_q.st == S_FIN);
    assign flags_upd_o = (r_q.st == S_FIN) || (r_q.st == S_REL);
    assign pc_o        = r_q.tgt;
    assign sp_o        = r_q.sp - AW'(2);
    assign iff1_o      = r_q.iff1;
    assign iff2_o      = r_q.iff2;
    assign ei_pend_o   = r_q.eip;
    assign halt_clr_o  = (r_q.st == S_FIN) && r_q.halt;

    // R3: the low-byte write follows the high-byte write one address lower
    p_push_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && !$past(mem_we_o)) |=>
        (mem_we_o && (mem_addr_o == $past(mem_addr_o) - AW'(1))));

    // R3: every acceptance begins with a stack write
    p_busy_starts_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> mem_we_o);

    // R6: the table high byte is read at the next address
    p_table_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && !$past(mem_rd_o)) |=>
        (mem_rd_o && (mem_addr_o == $past(mem_addr_o) + AW'(1))));

    // R4, R5: every acceptance leaves interrupts disabled
    p_done_clears_iff1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!iff1_o && !ei_pend_o));

    // R11: done follows the busy window and is a single pulse
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: stack writes and table reads never overlap
    p_no_rw_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_rd_o));

endmodule

// File: tb/irq_accept_seq_bench.sv
`timescale 1ns/1ps
module irq_accept_seq_bench;

    typedef struct packed {
        logic        nmi;
        logic        irq;
        logic        iff1;
        logic        iff2;
        logic        halt;
        logic [1:0]  im;
        logic [7:0]  vec;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  ir;
        logic        acc;
        logic        tbl;
        logic [15:0] epc;
        logic        eiff2;
    } row_t;

    localparam int NROW = 13;
    // nmi irq iff1 iff2 halt im vec pc sp ireg accepted table exp_pc exp_iff2
    localparam row_t ROWS [NROW] = '{
        '{1'b1,1'b0,1'b1,1'b0,1'b0,2'd1,8'h00,16'h1234,16'hF000,8'h00,1'b1,1'b0,16'h0066,1'b1}, // R4
        '{1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,8'h00,16'h4321,16'h8000,8'h00,1'b1,1'b0,16'h0066,1'b0}, // R4
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'd1,8'hA5,16'h0100,16'hF000,8'h00,1'b1,1'b0,16'h0038,1'b0}, // R7
        '{1'b0,1'b1,1'b0,1'b1,1'b0,2'd1,8'h00,16'h0100,16'hF000,8'h00,1'b0,1'b0,16'h0000,1'b0}, // R1
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,8'hD7,16'h0200,16'hE000,8'h00,1'b1,1'b0,16'h0010,1'b0}, // R8
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,8'hFF,16'h0200,16'hE000,8'h00,1'b1,1'b0,16'h0038,1'b0}, // R8
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,8'hC7,16'h0200,16'hE000,8'h00,1'b1,1'b0,16'h0000,1'b0}, // R8
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,8'h55,16'h0ABC,16'hE000,8'h00,1'b1,1'b0,16'h0ABC,1'b0}, // R8
        '{1'b0,1'b1,1'b1,1'b1,1'b0,2'd2,8'h40,16'h3000,16'hD000,8'h80,1'b1,1'b1,16'h9B9A,1'b0}, // R6
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'd1,8'h00,16'h2000,16'hC000,8'h00,1'b1,1'b0,16'h0038,1'b0}, // R9
        '{1'b1,1'b1,1'b1,1'b1,1'b0,2'd2,8'h40,16'h5555,16'hB000,8'h80,1'b1,1'b0,16'h0066,1'b1}, // R2
        '{1'b0,1'b1,1'b1,1'b0,1'b1,2'd2,8'hFE,16'h7FFF,16'h0000,8'h00,1'b1,1'b1,16'hA5A4,1'b0}, // R3 R9
        '{1'b0,1'b1,1'b1,1'b0,1'b0,2'd3,8'h34,16'h0001,16'h0001,8'h12,1'b1,1'b1,16'h7D7C,1'b0}  // R3 R6
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0;
    logic        nmi_req_i = 1'b0;
    logic        int_req_i = 1'b0;
    logic [7:0]  vec_i = '0;
    logic        iff1_i = 1'b0;
    logic        iff2_i = 1'b0;
    logic        ei_pend_i = 1'b0;
    logic        halt_i = 1'b0;
    logic [1:0]  im_i = '0;
    logic [15:0] pc_i = '0;
    logic [15:0] sp_i = '0;
    logic [7:0]  ireg_i = '0;
    logic        mem_we_o, mem_rd_o;
    logic [15:0] mem_addr_o;
    logic [7:0]  mem_wdata_o;
    logic [7:0]  mem_rdata_i;
    logic        busy_o, done_o, flags_upd_o;
    logic [15:0] pc_o, sp_o;
    logic        iff1_o, iff2_o, ei_pend_o, halt_clr_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    irq_accept_seq u_irq_accept_seq (
        .clk, .rst_n, .step_i, .nmi_req_i, .int_req_i, .vec_i, .iff1_i, .iff2_i,
        .ei_pend_i, .halt_i, .im_i, .pc_i, .sp_i, .ireg_i, .mem_we_o, .mem_rd_o,
        .mem_addr_o, .mem_wdata_o, .mem_rdata_i, .busy_o, .done_o, .flags_upd_o,
        .pc_o, .sp_o, .iff1_o, .iff2_o, .ei_pend_o, .halt_clr_o
    );

    // memory model: each byte is a function of its address, one cycle latency
    always_ff @(posedge clk) begin
        mem_rdata_i <= mem_rd_o ? (mem_addr_o[7:0] ^ mem_addr_o[15:8] ^ 8'h5A) : 8'h00;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    int          o_wn, o_done, o_upd;
    logic [15:0] o_wa [2];
    logic [7:0]  o_wd [2];
    logic [15:0] o_pc, o_sp;
    logic        o_iff1, o_iff2, o_eip, o_hclr, o_busy1;

    // one step pulse, then watch eight falling edges
    task automatic pulse_watch();
        o_wn = 0; o_done = 0; o_upd = 0; o_busy1 = 1'b0; o_hclr = 1'b0;
        step_i = 1'b1;
        @(negedge clk);
        step_i = 1'b0;
        for (int n = 1; n <= 8; n++) begin
            if (n > 1) @(negedge clk);
            if (n == 1) o_busy1 = busy_o;
            if (mem_we_o) begin
                if (o_wn < 2) begin
                    o_wa[o_wn] = mem_addr_o;
                    o_wd[o_wn] = mem_wdata_o;
                end
                o_wn++;
            end
            if (done_o && o_done == 0) begin
                o_done = n; o_pc = pc_o; o_sp = sp_o;
            end
            if (done_o) o_hclr = halt_clr_o;
            if (flags_upd_o && o_upd == 0) begin
                o_upd = n; o_iff1 = iff1_o; o_iff2 = iff2_o; o_eip = ei_pend_o;
            end
        end
    endtask

    task automatic run_row(input row_t v);
        logic [15:0] pp;
        nmi_req_i = v.nmi; int_req_i = v.irq; iff1_i = v.iff1; iff2_i = v.iff2;
        halt_i = v.halt; im_i = v.im; vec_i = v.vec; pc_i = v.pc; sp_i = v.sp;
        ireg_i = v.ir; ei_pend_i = 1'b0;
        pulse_watch();
        pp = v.pc + {15'd0, v.halt};
        if (v.acc) begin
            chk(o_wn == 2, "R3 write count", o_wn, 2);
            chk(o_wa[0] == v.sp - 16'd1, "R3 high byte address", o_wa[0], v.sp - 16'd1);
            chk(o_wd[0] == pp[15:8], "R3 R9 high byte data", o_wd[0], pp[15:8]);
            chk(o_wa[1] == v.sp - 16'd2, "R3 low byte address", o_wa[1], v.sp - 16'd2);
            chk(o_wd[1] == pp[7:0], "R3 R9 low byte data", o_wd[1], pp[7:0]);
            chk(o_busy1, "R11 busy after step", o_busy1, 1);
            chk(o_done == (v.tbl ? 6 : 3), "R11 done cycle", o_done, v.tbl ? 6 : 3);
            chk(o_pc == v.epc, "R2 R4 R6 R7 R8 new pc", o_pc, v.epc);
            chk(o_sp == v.sp - 16'd2, "R3 new sp", o_sp, v.sp - 16'd2);
            chk(o_upd == o_done, "R11 flags with done", o_upd, o_done);
            chk(!o_iff1 && !o_eip, "R4 R5 iff1 and pending cleared", {o_iff1, o_eip}, 0);
            chk(o_iff2 == v.eiff2, "R4 R5 iff2", o_iff2, v.eiff2);
            chk(o_hclr == v.halt, "R9 halt clear", o_hclr, v.halt);
        end else begin
            chk(o_wn == 0, "R1 no write when masked", o_wn, 0);
            chk(o_done == 0 && !o_busy1, "R1 no acceptance when masked", o_done, 0);
        end
        nmi_req_i = 1'b0; int_req_i = 1'b0; halt_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !flags_upd_o, "R11 reset idle", {busy_o, done_o, flags_upd_o}, 0);
        chk(!mem_we_o && !mem_rd_o, "R3 reset no memory access", {mem_we_o, mem_rd_o}, 0);
        chk(!iff1_o && !iff2_o && !ei_pend_o, "R5 reset flags", {iff1_o, iff2_o, ei_pend_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NROW; i++) run_row(ROWS[i]);

        // R10: hold-off then accept at the following step
        pc_i = 16'h0600; sp_i = 16'hA000; im_i = 2'd1; vec_i = 8'h00; halt_i = 1'b0;
        iff1_i = 1'b0; iff2_i = 1'b0; ei_pend_i = 1'b1; int_req_i = 1'b1; nmi_req_i = 1'b0;
        pulse_watch();
        chk(o_wn == 0 && o_done == 0, "R10 refused at first step", o_wn, 0);
        chk(o_upd == 0, "R10 no flag update at first step", o_upd, 0);
        pulse_watch();
        chk(o_done == 3, "R10 accepted at second step", o_done, 3);
        chk(o_pc == 16'h0038, "R10 R7 pc", o_pc, 16'h0038);
        chk(!o_iff1 && !o_iff2 && !o_eip, "R10 R5 flags", {o_iff1, o_iff2, o_eip}, 0);

        // R10: release without a request
        int_req_i = 1'b0; ei_pend_i = 1'b1; iff2_i = 1'b1;
        pulse_watch();
        chk(o_upd == 0 && o_done == 0, "R10 quiet first step", o_upd, 0);
        pulse_watch();
        chk(o_upd == 1 && o_done == 0, "R10 release update cycle", o_upd, 1);
        chk(o_iff1 && !o_eip, "R10 release sets iff1", {o_iff1, o_eip}, 2);
        chk(o_wn == 0, "R10 release no write", o_wn, 0);

        // R10: non-maskable taken at the first pending step
        ei_pend_i = 1'b1; iff1_i = 1'b0; iff2_i = 1'b1; nmi_req_i = 1'b1;
        pulse_watch();
        chk(o_done == 3 && o_pc == 16'h0066, "R10 R4 nmi during hold", o_pc, 16'h0066);
        chk(!o_iff2 && !o_eip, "R10 R4 nmi flags", {o_iff2, o_eip}, 0);
        nmi_req_i = 1'b0; ei_pend_i = 1'b0;

        // R1: a step with no request does nothing
        int_req_i = 1'b0; iff1_i = 1'b1;
        pulse_watch();
        chk(o_wn == 0 && o_done == 0 && o_upd == 0, "R1 idle step", o_wn, 0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule